// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Mover

The block moves one transfer at a time from a valid/ready data stream into memory. It takes a command holding a start address, a byte length and an address-increment flag. It then accepts stream words into an internal write FIFO and drains them through a memory-mapped burst write master. When the transfer ends, the block presents a status token with the number of bytes it actually wrote. It accepts its next command only after that token has been taken.

Every burst carries exactly `MAX_BURST` words, except the last burst of a transfer, which carries whatever is left. A burst is claimed only once all of its words are already in the FIFO, so a burst never stalls partway for lack of data. The FIFO holds `2*MAX_BURST` words, which lets the stream keep filling one burst while the previous one drains. A stream word flagged as end-of-packet ends the transfer early. In that case the status reports the shorter count and raises an early-termination flag.

Back-pressure works as follows. A stream word moves only in a cycle where `s_valid` and `s_ready` are both high, and `s_ready` never depends on `s_valid`. A command moves when `cmd_valid` and `cmd_ready` are both high. A status token moves when `sts_valid` and `sts_ready` are both high. A write beat is taken in a cycle where `wr_valid` is high and `wr_wait` is low.

Top module: `burst_write_mover`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `wr_valid`, `s_ready` and `sts_valid` are 0; while idle, no write and no stream word is taken.
- R2: `cmd_ready` is low from the cycle after a command is accepted until the status token has been taken, and is high again the cycle after that handshake.
- R3: Bursts in one transfer carry `MAX_BURST` words (4 by default), except the last, which carries the remainder; `wr_burst` equals the number of beats that follow.
- R4: A burst begins only when the write FIFO already holds all of its words, so `wr_valid` is never high with the FIFO empty.
- R5: With `cmd_incr`=1, each burst address is the previous burst address plus 4 times the previous burst count; with `cmd_incr`=0, every burst uses `cmd_addr`.
- R6: While `wr_valid` is high and `wr_wait` is high, `wr_addr`, `wr_burst` and `wr_data` hold their values into the next cycle.
- R7: Stream words are written in arrival order, each exactly once.
- R8: The status appears only after the last write beat of the transfer has been taken; `sts_bytes` is 4 times the words written. The transfer length is `cmd_len`/4 words; the two low bits of `cmd_len` are ignored.
- R9: A stream word with `s_eop`=1 that arrives before the length is reached is the transfer's last word, and `sts_early` is 1. If `s_eop` arrives on exactly the final word, `sts_early` is 0.
- R10: `s_ready` is low while the write FIFO holds `2*MAX_BURST` words, and stays low once the transfer's words have all been taken.
- R11: A command with a length below 4 bytes writes nothing, takes no stream word and returns a status of 0 bytes.
- R12: `sts_valid`, `sts_bytes` and `sts_early` hold until `sts_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, will take a command |
| cmd_addr | input | ADDR_W | First write address (bytes) |
| cmd_len | input | LEN_W | Transfer length in bytes |
| cmd_incr | input | 1 | 1: address advances per beat; 0: fixed address |
| s_valid | input | 1 | Stream word offered |
| s_ready | output | 1 | Stream word will be taken |
| s_data | input | DATA_W | Stream word |
| s_eop | input | 1 | Word ends the packet |
| wr_valid | output | 1 | Write beat presented |
| wr_wait | input | 1 | Memory stalls the current beat |
| wr_addr | output | ADDR_W | Burst start address |
| wr_burst | output | BC_W | Beats in the current burst |
| wr_data | output | DATA_W | Write beat data |
| sts_valid | output | 1 | Status token offered |
| sts_ready | input | 1 | Status token taken |
| sts_bytes | output | LEN_W | Bytes actually written |
| sts_early | output | 1 | Transfer ended by end-of-packet |

## Verification
The FIFO is filled by the stream side and drained by the write master in the same clock cycle. In that same cycle, new words are added to the unclaimed-word tally while a burst claim removes words from it. The bench provokes this overlap with a stream that has gaps every third cycle, set against pseudo-random `wr_wait` stalls, and with a long write stall that fills the FIFO before draining it. Each case is judged by the order and count of the written words, the burst lengths and addresses, and the byte count in the status.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
  typedef enum logic [1:0] {
    BWM_IDLE   = 2'd0,
    BWM_RUN    = 2'd1,
    BWM_STATUS = 2'd2
  } bwm_state_e;
endpackage

// File: rtl/bwm_fifo.sv
`timescale 1ns/1ps
module bwm_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign pop_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // the stream side must respect the full flag
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // the write side only drains words that are present
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/bwm_ingest.sv
`timescale 1ns/1ps
module bwm_ingest #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_words,
  input  logic          active,
  input  logic          s_valid,
  input  logic          s_eop,
  input  logic          fifo_full,
  output logic          s_ready,
  output logic          push,
  output logic [LW-1:0] words_in,
  output logic          early,
  output logic          done
);
  logic [LW-1:0] left;

  assign s_ready = active && !done && !fifo_full;
  assign push    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left     <= '0;
      words_in <= '0;
      early    <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      left     <= start_words;
      words_in <= '0;
      early    <= 1'b0;
      done     <= (start_words == '0);
    end else if (push) begin
      left     <= left - 1'b1;
      words_in <= words_in + 1'b1;
      if (s_eop || left == LW'(1)) done <= 1'b1;
      if (s_eop && left != LW'(1)) early <= 1'b1;
    end
  end

  // an end-of-packet word closes the intake at once
  assert_stop_at_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push && s_eop |=> !s_ready);
endmodule

// File: rtl/bwm_burst.sv
`timescale 1ns/1ps
module bwm_burst #(
  parameter int AW   = 32,
  parameter int MAXB = 4,
  parameter int BCW  = $clog2(MAXB) + 1,
  parameter int CW   = $clog2(2 * MAXB + 1),
  parameter int BSH  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic           start_incr,
  input  logic           active,
  input  logic           push,
  input  logic           ingest_done,
  input  logic           fifo_empty,
  input  logic [CW-1:0]  fifo_count,
  input  logic           wr_wait,
  output logic           wr_valid,
  output logic [AW-1:0]  wr_addr,
  output logic [BCW-1:0] wr_burst,
  output logic           pop,
  output logic           idle
);
  localparam logic [CW-1:0] MAXB_C = CW'(MAXB);

  logic           busy;
  logic           incr_q;
  logic [AW-1:0]  cur_addr;
  logic [BCW-1:0] beats_left;
  logic [CW-1:0]  unissued;
  logic [BCW-1:0] claim_len;
  logic           claim;

  assign claim_len = (unissued >= MAXB_C) ? BCW'(MAXB) : BCW'(unissued);
  assign claim     = active && !busy &&
                     ((unissued >= MAXB_C) || (ingest_done && unissued != '0));
  assign wr_valid  = busy;
  assign pop       = busy && !wr_wait;
  assign idle      = !busy && (unissued == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      incr_q     <= 1'b0;
      cur_addr   <= '0;
      beats_left <= '0;
      unissued   <= '0;
      wr_addr    <= '0;
      wr_burst   <= '0;
    end else begin
      if (start) begin
        cur_addr <= start_addr;
        incr_q   <= start_incr;
      end
      unissued <= unissued + CW'(push) - (claim ? CW'(claim_len) : CW'(0));
      if (claim) begin
        busy       <= 1'b1;
        wr_addr    <= cur_addr;
        wr_burst   <= claim_len;
        beats_left <= claim_len;
        if (incr_q) cur_addr <= cur_addr + (AW'(claim_len) << BSH);
      end else if (pop) begin
        beats_left <= beats_left - 1'b1;
        if (beats_left == BCW'(1)) busy <= 1'b0;
      end
    end
  end

  assert_burst_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> fifo_count >= CW'(wr_burst));
  assert_data_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !fifo_empty);
  assert_short_only_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) && wr_burst != BCW'(MAXB) |-> ingest_done);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_wait |=> wr_valid && $stable(wr_addr) && $stable(wr_burst));
endmodule

// File: rtl/burst_write_mover.sv
`timescale 1ns/1ps
module burst_write_mover #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 4,
  parameter int BC_W      = $clog2(MAX_BURST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_incr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_eop,
  output logic              wr_valid,
  input  logic              wr_wait,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BC_W-1:0]   wr_burst,
  output logic [DATA_W-1:0] wr_data,
  output logic              sts_valid,
  input  logic              sts_ready,
  output logic [LEN_W-1:0]  sts_bytes,
  output logic              sts_early
);
  import bwm_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);
  localparam int DEPTH = 2 * MAX_BURST;
  localparam int CNT_W = $clog2(DEPTH + 1);

  bwm_state_e       state;
  logic             start, active;
  logic [LEN_W-1:0] cmd_words, words_in;
  logic             ing_done, ing_early, push, pop, burst_idle;
  logic             fifo_full, fifo_empty;
  logic [CNT_W-1:0] fifo_count;
  logic             unused_len_low;

  assign cmd_words      = {{BSH{1'b0}}, cmd_len[LEN_W-1:BSH]};
  assign unused_len_low = ^cmd_len[BSH-1:0];
  assign cmd_ready      = (state == BWM_IDLE);
  assign start          = cmd_valid && cmd_ready;
  assign active         = (state == BWM_RUN);
  assign sts_valid      = (state == BWM_STATUS);
  assign sts_bytes      = words_in << BSH;
  assign sts_early      = ing_early;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= BWM_IDLE;
    end else begin
      unique case (state)
        BWM_IDLE:   if (start) state <= BWM_RUN;
        BWM_RUN:    if (ing_done && burst_idle) state <= BWM_STATUS;
        BWM_STATUS: if (sts_ready) state <= BWM_IDLE;
        default:    state <= BWM_IDLE;
      endcase
    end
  end

  bwm_ingest #(.LW(LEN_W)) u_ingest (
    .clk(clk), .rst_n(rst_n), .start(start), .start_words(cmd_words),
    .active(active), .s_valid(s_valid), .s_eop(s_eop), .fifo_full(fifo_full),
    .s_ready(s_ready), .push(push), .words_in(words_in), .early(ing_early),
    .done(ing_done)
  );

  bwm_fifo #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(s_data), .pop(pop),
    .pop_data(wr_data), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  bwm_burst #(.AW(ADDR_W), .MAXB(MAX_BURST), .BCW(BC_W), .CW(CNT_W), .BSH(BSH)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(cmd_addr),
    .start_incr(cmd_incr), .active(active), .push(push), .ingest_done(ing_done),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count), .wr_wait(wr_wait),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_burst(wr_burst), .pop(pop),
    .idle(burst_idle)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !wr_valid && !s_ready);
  assert_status_after_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> !wr_valid && fifo_empty);
  assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_ready |=> sts_valid && $stable(sts_bytes) && $stable(sts_early));
  assert_reopen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && sts_ready |=> cmd_ready);
endmodule

// File: tb/burst_write_mover_tb.sv
`timescale 1ns/1ps
module burst_write_mover_tb;
  localparam int CLK_P = 10;
  localparam int MAXB  = 4;
  localparam int FDEP  = 2 * MAXB;
  localparam int NMON  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_incr = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        s_valid = 1'b0, s_eop = 1'b0, s_ready;
  logic [31:0] s_data = '0;
  logic        wr_valid;
  logic        wr_wait = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic [2:0]  wr_burst;
  logic        sts_valid, sts_early;
  logic        sts_ready = 1'b0;
  logic [15:0] sts_bytes;

  int checks = 0, fails = 0, mchecks = 0, mfails = 0, cyc = 0;
  int wmode = 0, sent = 0, nbeats = 0, nbursts = 0;
  bit stop_drv = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic [31:0] b_addr [NMON];
  logic [31:0] b_data [NMON];
  int          b_cnt  [NMON];
  int          bst_sent [NMON];
  bit          hold_prev = 1'b0, prev_v = 1'b0;
  logic [31:0] p_addr, p_data;
  logic [2:0]  p_cnt;

  always #(CLK_P/2) clk = ~clk;

  burst_write_mover #(.MAX_BURST(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_incr(cmd_incr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_eop(s_eop),
    .wr_valid(wr_valid), .wr_wait(wr_wait), .wr_addr(wr_addr),
    .wr_burst(wr_burst), .wr_data(wr_data), .sts_valid(sts_valid),
    .sts_ready(sts_ready), .sts_bytes(sts_bytes), .sts_early(sts_early)
  );

  // memory-side model: picks the stall for the coming edge, then records beats
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (wmode)
      1:       wr_wait = lfsr[0];
      2:       wr_wait = 1'b1;
      default: wr_wait = 1'b0;
    endcase
    if (rst_n) begin
      if (hold_prev) begin
        mchecks++;
        if (!wr_valid || wr_addr != p_addr || wr_burst != p_cnt || wr_data != p_data) begin
          mfails++;
          $display("FAIL R6 stalled beat changed: actual addr %0h cnt %0d expected addr %0h cnt %0d",
                   wr_addr, wr_burst, p_addr, p_cnt);
        end
      end
      hold_prev = wr_valid && wr_wait;
      p_addr = wr_addr; p_cnt = wr_burst; p_data = wr_data;
      if (wr_valid && !prev_v && nbursts < NMON) begin
        bst_sent[nbursts] = sent;
        nbursts++;
      end
      prev_v = wr_valid;
      if (wr_valid && !wr_wait && nbeats < NMON) begin
        b_addr[nbeats] = wr_addr;
        b_data[nbeats] = wr_data;
        b_cnt[nbeats]  = int'(wr_burst);
        nbeats++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      $display("FAIL R2 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks + 1, fails + mfails + 1);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_stream(int n_drive, int eop_idx, bit gap, logic [31:0] dbase);
    int i = 0;
    int g = 0;
    while (i < n_drive && !stop_drv) begin
      @(negedge clk);
      s_valid = gap ? ((g % 3) != 1) : 1'b1;
      g++;
      s_data = dbase + i;
      s_eop  = (i == eop_idx);
      if (s_valid && s_ready) begin
        i++;
        sent = i;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_eop   = 1'b0;
  endtask

  // one transfer: command, stream, status, then per-beat comparison
  task automatic run_cmd(string name, logic [31:0] addr, int nwords, bit incr, int n_drive,
                         int eop_idx, bit gap, int wm, logic [31:0] dbase, int hold);
    int n_eff, b0, nb0, exp_nb, j, len_j;
    logic [15:0] got_bytes;
    n_eff = (eop_idx >= 0) ? ((eop_idx + 1 < nwords) ? eop_idx + 1 : nwords)
                           : ((n_drive < nwords) ? n_drive : nwords);
    b0 = nbeats; nb0 = nbursts; sent = 0; stop_drv = 1'b0;
    wmode = (hold > 0) ? 2 : wm;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = 16'(nwords * 4); cmd_incr = incr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2", {name, " busy after accept"}, cmd_ready, 0);
    fork
      drive_stream(n_drive, eop_idx, gap, dbase);
      begin
        if (hold > 0) begin
          repeat (hold) @(negedge clk);
          check(sent == FDEP, "R10", {name, " words taken while writes stall"}, sent, FDEP);
          check(s_ready == 1'b0, "R10", {name, " s_ready with full FIFO"}, s_ready, 0);
          wmode = 0;
        end
      end
      begin
        do @(negedge clk); while (!sts_valid);
        check(nbeats - b0 == n_eff, "R8", {name, " beats done before status"}, nbeats - b0, n_eff);
        check(sts_bytes == 16'(n_eff * 4), "R8", {name, " status bytes"}, sts_bytes, n_eff * 4);
        check(sts_early == ((eop_idx >= 0) && (eop_idx + 1 < nwords)), "R9",
              {name, " early flag"}, sts_early, ((eop_idx >= 0) && (eop_idx + 1 < nwords)));
        check(cmd_ready == 1'b0, "R2", {name, " no command while status pending"}, cmd_ready, 0);
        got_bytes = sts_bytes;
        repeat (2) @(negedge clk);
        check(sts_valid && sts_bytes == got_bytes, "R12", {name, " status held"}, sts_bytes, got_bytes);
        sts_ready = 1'b1;
        @(negedge clk);
        sts_ready = 1'b0;
        check(cmd_ready == 1'b1 && sts_valid == 1'b0, "R2", {name, " idle after status"}, cmd_ready, 1);
        stop_drv = 1'b1;
      end
    join
    check(sent == n_eff, (nwords == 0) ? "R11" : "R10", {name, " stream words taken"}, sent, n_eff);
    exp_nb = (n_eff + MAXB - 1) / MAXB;
    check(nbursts - nb0 == exp_nb, "R3", {name, " burst count"}, nbursts - nb0, exp_nb);
    for (int k = 0; k < n_eff; k++) begin
      j = k / MAXB;
      len_j = (n_eff - j * MAXB < MAXB) ? n_eff - j * MAXB : MAXB;
      check(b_data[b0 + k] == dbase + k, "R7", {name, " beat data"}, b_data[b0 + k], dbase + k);
      check(b_cnt[b0 + k] == len_j, "R3", {name, " burst length"}, b_cnt[b0 + k], len_j);
      check(b_addr[b0 + k] == (incr ? addr + 32'(j * MAXB * 4) : addr), "R5", {name, " burst address"},
            b_addr[b0 + k], incr ? addr + 32'(j * MAXB * 4) : addr);
    end
    for (int q = 0; q < exp_nb && nb0 + q < nbursts; q++) begin
      len_j = (n_eff - q * MAXB < MAXB) ? n_eff - q * MAXB : MAXB;
      check(bst_sent[nb0 + q] >= q * MAXB + len_j, "R4", {name, " burst data buffered"},
            bst_sent[nb0 + q], q * MAXB + len_j);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    check(wr_valid == 1'b0 && s_ready == 1'b0, "R1", "write/stream quiet after reset", wr_valid | s_ready, 0);
    check(sts_valid == 1'b0, "R1", "no status after reset", sts_valid, 0);
  endtask

  task automatic t_exact();     run_cmd("exact",   32'h1000, 10, 1'b1, 13, -1, 1'b0, 0, 32'hA000, 0); endtask
  task automatic t_stalls();    run_cmd("stalls",  32'h2000,  9, 1'b1,  9, -1, 1'b1, 1, 32'hB000, 0); endtask
  task automatic t_fixed();     run_cmd("fixed",   32'h3000,  6, 1'b0,  6, -1, 1'b0, 1, 32'hC000, 0); endtask
  task automatic t_early();     run_cmd("early",   32'h4000, 12, 1'b1, 12,  4, 1'b1, 0, 32'hD000, 0); endtask
  task automatic t_eop_last();  run_cmd("eoplast", 32'h5000,  8, 1'b1,  8,  7, 1'b0, 1, 32'hE000, 0); endtask
  task automatic t_zero();      run_cmd("zero",    32'h6000,  0, 1'b1,  3, -1, 1'b0, 0, 32'hF000, 0); endtask
  task automatic t_full();      run_cmd("full",    32'h7000, 16, 1'b1, 16, -1, 1'b0, 0, 32'h1100, 40); endtask
  task automatic t_one_burst(); run_cmd("oneb",    32'h8000,  4, 1'b1,  4, -1, 1'b1, 1, 32'h2200, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact();
    t_stalls();
    t_fixed();
    t_early();
    t_eop_last();
    t_zero();
    t_full();
    t_one_burst();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule